// File: doc/BRIEF.md
# Thread-Block Dispatcher with Resource Accounting

This block takes one kernel launch at a time and hands its thread blocks to a set of compute cores. A launch carries three numbers: how many blocks make up the grid, how many threads each block has, and how many bytes of on-chip shared memory each block needs. Threads are packed into warps of a fixed width. A block therefore claims a whole number of warp contexts, and all of them must sit on one core. Each core has a fixed budget of warp contexts and shared-memory bytes. The dispatcher keeps a free count of both for every core and places a block only where both counts cover its needs.

Blocks have no dependencies on each other. They leave in ascending ID order, at most one per clock, each to the lowest-numbered core that can hold it. When a core finishes a block, it reports the warp and byte amounts that block held, and the dispatcher returns them to that core's free counts. The grid ends as a barrier: a one-cycle completion pulse fires only once every block has been issued and every block has been reported done. A launch that asks for more than a single core can ever provide is refused and raises an error flag.

Top module: `block_dispatcher`

## Requirements
- R1: After reset, `busy`, `dispValid`, `gridDone` and `launchError` are all 0, and every core's free budget is full: 64 warp contexts and 49152 shared-memory bytes.
- R2: A block needs ceil(threads/32) warp contexts. It is issued to a core only when that core's free warp count and free shared-memory byte count both cover the block's needs. While a core holds blocks, those amounts are subtracted from its budget.
- R3: Block IDs leave in ascending order, starting at 0 and ending at grid-1. Each ID leaves exactly once, and at most one block is dispatched per clock.
- R4: When several cores can hold the next block, `dispCore` is the lowest-numbered of them.
- R5: A completion report is a `doneValid` bit for a core, together with that core's warp and byte amounts. At the clock edge where it is sampled, it adds those amounts back to the core's budget. The freed room can be used by a dispatch in the very next cycle.
- R6: `gridDone` pulses for one cycle once all blocks have been issued and all have been reported done. `busy` falls in the cycle after that pulse.
- R7: A launch is refused when its thread count is 0, when it needs more than 64 warps, or when it needs more than 49152 bytes. A refused launch sets `launchError`, dispatches nothing and leaves `busy` at 0. `launchError` stays at 1 until a launch is accepted.
- R8: A `launchValid` pulse that arrives while `busy` is 1 is ignored. The running grid carries on unchanged.
- R9: A launch with a grid of 0 blocks dispatches nothing. `gridDone` pulses in the first cycle after the launch is sampled.
- R10: No core's free warp count ever exceeds 64, and no core's free byte count ever exceeds 49152. Neither count wraps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | Launch command strobe, taken when idle |
| launchThreads | input | 12 | Threads per block |
| launchShmem | input | 16 | Shared-memory bytes per block |
| launchGrid | input | 8 | Number of blocks in the grid |
| busy | output | 1 | A grid is being dispatched or drained |
| launchError | output | 1 | Last launch was refused |
| doneValid | input | 4 | Per-core block-complete report |
| doneWarps | input | 28 | Per-core warp count being returned, 7 bits per core, core 0 in the low bits |
| doneShmem | input | 64 | Per-core byte count being returned, 16 bits per core, core 0 in the low bits |
| dispValid | output | 1 | A block is dispatched this cycle |
| dispCore | output | 2 | Core receiving the block |
| dispBlockId | output | 8 | ID of the dispatched block |
| gridDone | output | 1 | One-cycle grid completion pulse |

## Verification
The main function is tried with several kinds of launch:
- Small blocks that all fit on core 0 show that the lowest core is preferred and that issue runs back to back.
- Full-core blocks, limited by warps, spread one per core and then wait for completions. This separates "room freed" from "room in use".
- Blocks limited by shared memory test the byte budget on its own.
- A 1025-thread block needs 33 warps, so only one fits per core. This tells a rounded-up warp count apart from a truncated one.
- Per-block lifetimes that vary make completions arrive out of order and at the same time as dispatches.
- Refused launches, a zero-block grid and a launch pulse sent mid-grid cover the edge paths.

// File: rtl/disp_pkg.sv
package disp_pkg;

  typedef struct packed {
    logic loadCmd;
    logic rejectCmd;
    logic issue;
    logic finish;
  } dispStrobes_t;

endpackage

// File: rtl/disp_ctrl.sv
module disp_ctrl
  import disp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         launchValid,
  input  logic         cmdBad,
  input  logic         haveWork,
  input  logic         anyFit,
  input  logic         allRetired,
  output dispStrobes_t strobes,
  output logic         busy,
  output logic         gridDone
);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;

  ctrlState_t state;
  ctrlState_t stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (launchValid) begin
          if (cmdBad) begin
            strobes.rejectCmd = 1'b1;
          end else begin
            strobes.loadCmd = 1'b1;
            stateNext       = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        strobes.issue = haveWork && anyFit;
        if (!haveWork && allRetired) begin
          strobes.finish = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy     = (state == ST_RUN);
  assign gridDone = strobes.finish;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    gridDone |=> !gridDone); // R6
  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    gridDone |=> !busy); // R6
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rejectCmd |=> !busy); // R7
  AST_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issue |-> busy); // R8

endmodule

// File: rtl/disp_datapath.sv
module disp_datapath
  import disp_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int WARP_SIZE   = 32,
  parameter int MAX_WARPS   = 64,
  parameter int SHMEM_BYTES = 49152,
  parameter int THR_W       = 12,
  parameter int GRID_W      = 8,
  parameter int WARP_W      = 7,
  parameter int SMEM_W      = 16,
  parameter int CORE_W      = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dispStrobes_t                strobes,
  input  logic [THR_W-1:0]            launchThreads,
  input  logic [SMEM_W-1:0]           launchShmem,
  input  logic [GRID_W-1:0]           launchGrid,
  input  logic [NUM_CORES-1:0]        doneValid,
  input  logic [NUM_CORES*WARP_W-1:0] doneWarps,
  input  logic [NUM_CORES*SMEM_W-1:0] doneShmem,
  output logic                        cmdBad,
  output logic                        haveWork,
  output logic                        anyFit,
  output logic                        allRetired,
  output logic [CORE_W-1:0]           dispCore,
  output logic [GRID_W-1:0]           dispBlockId,
  output logic                        errFlag
);

  localparam int WARP_SHIFT = $clog2(WARP_SIZE);
  localparam int NEED_W     = THR_W + 1;

  logic [NEED_W-1:0] needWarpsIn;
  logic [WARP_W-1:0] reqWarps;
  logic [SMEM_W-1:0] reqShmem;
  logic [GRID_W-1:0] gridSize;
  logic [GRID_W-1:0] nextId;
  logic [GRID_W-1:0] outstanding;
  logic [GRID_W-1:0] doneCount;

  logic [WARP_W-1:0] freeW     [NUM_CORES];
  logic [SMEM_W-1:0] freeS     [NUM_CORES];
  logic [WARP_W-1:0] freeWNext [NUM_CORES];
  logic [SMEM_W-1:0] freeSNext [NUM_CORES];
  logic [NUM_CORES-1:0] fitVec;

  // Launch screening: warps rounded up, then compared with one core's budget.
  assign needWarpsIn = ({1'b0, launchThreads} + NEED_W'(WARP_SIZE - 1)) >> WARP_SHIFT;
  assign cmdBad      = (launchThreads == '0)
                    || (needWarpsIn > NEED_W'(MAX_WARPS))
                    || (launchShmem > SMEM_W'(SHMEM_BYTES));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqWarps <= '0;
      reqShmem <= '0;
      gridSize <= '0;
      errFlag  <= 1'b0;
    end else begin
      if (strobes.loadCmd) begin
        reqWarps <= needWarpsIn[WARP_W-1:0];
        reqShmem <= launchShmem;
        gridSize <= launchGrid;
        errFlag  <= 1'b0;
      end else if (strobes.rejectCmd) begin
        errFlag  <= 1'b1;
      end
    end
  end

  // Per-core fit detection.
  for (genvar g = 0; g < NUM_CORES; g++) begin : g_fit
    assign fitVec[g] = (freeW[g] >= reqWarps) && (freeS[g] >= reqShmem);

    AST_WARP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      freeW[g] <= WARP_W'(MAX_WARPS)); // R10
    AST_SHMEM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      freeS[g] <= SMEM_W'(SHMEM_BYTES)); // R10
    AST_ISSUE_CLAIMS: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.issue && dispCore == CORE_W'(g) && !doneValid[g])
        |=> freeW[g] == $past(freeW[g]) - $past(reqWarps)); // R2
  end

  assign anyFit = |fitVec;

  // Lowest-numbered core with room wins.
  always_comb begin
    dispCore = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (fitVec[c]) dispCore = CORE_W'(c);
    end
  end

  // Budget update: claim on issue, refund on completion report.
  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      freeWNext[c] = freeW[c];
      freeSNext[c] = freeS[c];
      if (strobes.issue && dispCore == CORE_W'(c)) begin
        freeWNext[c] = freeWNext[c] - reqWarps;
        freeSNext[c] = freeSNext[c] - reqShmem;
      end
      if (doneValid[c]) begin
        freeWNext[c] = freeWNext[c] + doneWarps[c*WARP_W +: WARP_W];
        freeSNext[c] = freeSNext[c] + doneShmem[c*SMEM_W +: SMEM_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CORES; c++) begin
      if (!rstN) begin
        freeW[c] <= WARP_W'(MAX_WARPS);
        freeS[c] <= SMEM_W'(SHMEM_BYTES);
      end else begin
        freeW[c] <= freeWNext[c];
        freeS[c] <= freeSNext[c];
      end
    end
  end

  // Grid progress and completion barrier.
  always_comb begin
    doneCount = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      doneCount = doneCount + GRID_W'(doneValid[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextId      <= '0;
      outstanding <= '0;
    end else begin
      if (strobes.loadCmd) begin
        nextId      <= '0;
        outstanding <= '0;
      end else begin
        if (strobes.issue) nextId <= nextId + 1'b1;
        outstanding <= outstanding + GRID_W'(strobes.issue) - doneCount;
      end
    end
  end

  assign haveWork    = (nextId != gridSize);
  assign allRetired  = (outstanding == '0);
  assign dispBlockId = nextId;

  AST_ID_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.issue && $past(strobes.issue) && !$past(strobes.loadCmd))
      |-> dispBlockId == $past(dispBlockId) + 1'b1); // R3
  AST_LOAD_FROM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCmd |=> dispBlockId == '0); // R3

endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher
  import disp_pkg::*;
#(
  parameter  int NUM_CORES   = 4,
  parameter  int WARP_SIZE   = 32,
  parameter  int MAX_WARPS   = 64,
  parameter  int SHMEM_BYTES = 49152,
  parameter  int THR_W       = 12,
  parameter  int GRID_W      = 8,
  localparam int WARP_W      = $clog2(MAX_WARPS + 1),
  localparam int SMEM_W      = $clog2(SHMEM_BYTES + 1),
  localparam int CORE_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        launchValid,
  input  logic [THR_W-1:0]            launchThreads,
  input  logic [SMEM_W-1:0]           launchShmem,
  input  logic [GRID_W-1:0]           launchGrid,
  output logic                        busy,
  output logic                        launchError,
  input  logic [NUM_CORES-1:0]        doneValid,
  input  logic [NUM_CORES*WARP_W-1:0] doneWarps,
  input  logic [NUM_CORES*SMEM_W-1:0] doneShmem,
  output logic                        dispValid,
  output logic [CORE_W-1:0]           dispCore,
  output logic [GRID_W-1:0]           dispBlockId,
  output logic                        gridDone
);

  dispStrobes_t strobes;
  logic cmdBad;
  logic haveWork;
  logic anyFit;
  logic allRetired;

  disp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .launchValid(launchValid),
    .cmdBad     (cmdBad),
    .haveWork   (haveWork),
    .anyFit     (anyFit),
    .allRetired (allRetired),
    .strobes    (strobes),
    .busy       (busy),
    .gridDone   (gridDone)
  );

  disp_datapath #(
    .NUM_CORES  (NUM_CORES),
    .WARP_SIZE  (WARP_SIZE),
    .MAX_WARPS  (MAX_WARPS),
    .SHMEM_BYTES(SHMEM_BYTES),
    .THR_W      (THR_W),
    .GRID_W     (GRID_W),
    .WARP_W     (WARP_W),
    .SMEM_W     (SMEM_W),
    .CORE_W     (CORE_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .launchThreads(launchThreads),
    .launchShmem  (launchShmem),
    .launchGrid   (launchGrid),
    .doneValid    (doneValid),
    .doneWarps    (doneWarps),
    .doneShmem    (doneShmem),
    .cmdBad       (cmdBad),
    .haveWork     (haveWork),
    .anyFit       (anyFit),
    .allRetired   (allRetired),
    .dispCore     (dispCore),
    .dispBlockId  (dispBlockId),
    .errFlag      (launchError)
  );

  assign dispValid = strobes.issue;

  AST_ONE_GRID_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && launchValid && !gridDone) |=> busy); // R8

endmodule

// File: tb/tb_block_dispatcher.sv
module tb_block_dispatcher;

  localparam int NC = 4;
  localparam int WW = 7;
  localparam int SW = 16;
  localparam int MAXW = 64;
  localparam int MAXS = 49152;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic launchValid = 1'b0;
  logic [11:0] launchThreads = '0;
  logic [SW-1:0] launchShmem = '0;
  logic [7:0] launchGrid = '0;
  logic busy, launchError, dispValid, gridDone;
  logic [NC-1:0] doneValid = '0;
  logic [NC*WW-1:0] doneWarps = '0;
  logic [NC*SW-1:0] doneShmem = '0;
  logic [1:0] dispCore;
  logic [7:0] dispBlockId;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int mFreeW [NC];
  int mFreeS [NC];
  int blkCore [256];
  int blkEnd  [256];
  bit blkRetired [256];

  always #5 clk = ~clk;

  block_dispatcher dut (
    .clk(clk), .rstN(rstN), .launchValid(launchValid),
    .launchThreads(launchThreads), .launchShmem(launchShmem), .launchGrid(launchGrid),
    .busy(busy), .launchError(launchError), .doneValid(doneValid),
    .doneWarps(doneWarps), .doneShmem(doneShmem), .dispValid(dispValid),
    .dispCore(dispCore), .dispBlockId(dispBlockId), .gridDone(gridDone)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic launch(input int thr, input int smem, input int grid);
    @(negedge clk);
    launchValid   = 1'b1;
    launchThreads = 12'(thr);
    launchShmem   = SW'(smem);
    launchGrid    = 8'(grid);
    @(posedge clk);
    @(negedge clk);
    launchValid = 1'b0;
  endtask

  // Runs a whole grid against a bench-side model of the core budgets.
  task automatic runKernel(input int thr, input int smem, input int grid,
                           input int life, input bit poke, input string tag);
    int need, nextId, outst, cyc;
    bit expIssue, expDone, stop;
    int expCore;
    need = (thr + 31) / 32;
    for (int i = 0; i < 256; i++) blkRetired[i] = 1'b0;
    launch(thr, smem, grid);
    chk(launchError == 1'b0, "R7 error cleared by accepted launch", launchError, 0);
    nextId = 0; outst = 0; cyc = 0; stop = 1'b0;
    while (!stop) begin
      expIssue = 1'b0; expCore = 0;
      if (nextId < grid) begin
        for (int c = NC - 1; c >= 0; c--)
          if (mFreeW[c] >= need && mFreeS[c] >= smem) begin expIssue = 1'b1; expCore = c; end
      end
      expDone = (nextId == grid) && (outst == 0);
      chk(dispValid == expIssue, {"R2 dispatch gating ", tag}, dispValid, expIssue);
      if (expIssue && dispValid) begin
        chk(dispBlockId == 8'(nextId), {"R3 block id order ", tag}, dispBlockId, nextId);
        chk(dispCore == 2'(expCore), {"R4 lowest fitting core ", tag}, dispCore, expCore);
      end
      chk(gridDone == expDone, {"R6 grid done pulse ", tag}, gridDone, expDone);
      if (poke) launchValid = (cyc == 2);
      if (expIssue) begin
        blkCore[nextId] = expCore;
        blkEnd[nextId]  = cyc + life + ((nextId * 7) % 5);
        mFreeW[expCore] -= need;
        mFreeS[expCore] -= smem;
        nextId++; outst++;
      end
      doneValid = '0; doneWarps = '0; doneShmem = '0;
      for (int c = 0; c < NC; c++) begin
        for (int b = 0; b < 256; b++) begin
          if (b < nextId - (expIssue ? 1 : 0) && !doneValid[c] && !blkRetired[b]
              && blkCore[b] == c && blkEnd[b] <= cyc) begin
            blkRetired[b] = 1'b1;
            doneValid[c] = 1'b1;
            doneWarps[c*WW +: WW] = WW'(need);
            doneShmem[c*SW +: SW] = SW'(smem);
            mFreeW[c] += need;
            mFreeS[c] += smem;
            outst--;
          end
        end
      end
      @(posedge clk);
      @(negedge clk);
      doneValid = '0;
      launchValid = 1'b0;
      cyc++;
      if (expDone) stop = 1'b1;
      if (cyc > 5000) begin
        chk(1'b0, {"R6 grid never finished ", tag}, cyc, 5000);
        stop = 1'b1;
      end
    end
    chk(busy == 1'b0, {"R6 busy falls after done ", tag}, busy, 0);
    chk(dispValid == 1'b0, {"R8 no stray dispatch ", tag}, dispValid, 0);
  endtask

  task automatic rejectCase(input int thr, input int smem, input string tag);
    launch(thr, smem, 5);
    for (int i = 0; i < 3; i++) begin
      chk(launchError == 1'b1, {"R7 error flag ", tag}, launchError, 1);
      chk(busy == 1'b0, {"R7 stays idle ", tag}, busy, 0);
      chk(dispValid == 1'b0, {"R7 no dispatch ", tag}, dispValid, 0);
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    chk(busy == 1'b0, "R1 busy at reset", busy, 0);
    chk(dispValid == 1'b0, "R1 dispValid at reset", dispValid, 0);
    chk(gridDone == 1'b0, "R1 gridDone at reset", gridDone, 0);
    chk(launchError == 1'b0, "R1 launchError at reset", launchError, 0);
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin mFreeW[c] = MAXW; mFreeS[c] = MAXS; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    // R1: full budgets shown by eight 64-warp... one full-core block per core fits at once
    runKernel(2048, MAXS, 4, 6, 1'b0, "R1 full budget");
    runKernel(128, 1024, 8, 5, 1'b0, "small blocks");
    runKernel(2048, 512, 6, 10, 1'b0, "R5 warp limited");
    runKernel(32, 30000, 10, 3, 1'b0, "shmem limited");
    runKernel(1025, 100, 9, 4, 1'b0, "R2 ceil 33 warps");
    runKernel(993, 0, 12, 2, 1'b0, "R2 ceil 32 warps");
    rejectCase(2049, 16, "R7 too many warps");
    rejectCase(64, MAXS + 1, "R7 too much shmem");
    rejectCase(0, 16, "R7 zero threads");
    runKernel(64, 2048, 0, 1, 1'b0, "R9 empty grid");
    runKernel(256, 8192, 20, 7, 1'b1, "R8 launch while busy");
    runKernel(32, 0, 40, 1, 1'b0, "R10 fast turnover");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule